// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the software-visible register layer of an I2C master controller. It decodes a 32-bit, word-aligned read/write bus. It holds the control word, the target device address, a bus timeout and a monitor pause value. It reflects the engine's live status flags and its remaining byte count. It also passes data-register accesses on to the FIFOs outside the block as single-cycle push and pop strobes.

Event pulses from the transfer engine are caught in a sticky interrupt status word. Software clears that word by writing ones to it. Each event has a mask bit. Software changes the mask only through a pair of registers: one that unmasks and one that masks. A single interrupt line is active whenever a stored event is unmasked. Writing the clear-FIFO control bit sends a one-cycle flush pulse to the FIFOs, and the bit then drops back to zero by itself.

Top module: `i2cm_csr`

## Requirements
- R1: After reset the control, address, timeout, pause and interrupt status registers read 0. The mask register (offset 0x20) reads 0x2FF, meaning every event is masked. `irq` and `fifo_flush` are low.
- R2: Control register (0x00) bits 0..5 (direction, master, 7-bit addressing, ACK enable, hold, monitor) and bits 13:8 (divider B) and 15:14 (divider A) read back as written and drive the matching `ctl_*` outputs. All other bits read 0.
- R3: A control write with bit 6 set makes `fifo_flush` high, and bit 6 read back as 1, for exactly the one cycle after that write. Both are 0 in the cycle after that.
- R4: An event pulse on `evt_pulse` bit k sets interrupt status (0x10) bit k, and the bit stays set until software clears it.
- R5: Writing interrupt status clears the bits written as 1 and leaves the bits written as 0. Writing 0xFF clears bits 0..7 and leaves bit 9 (arbitration lost).
- R6: When an event and a clear reach the same status bit in the same cycle, the bit ends up set.
- R7: A 1 written to the unmask register (0x24) clears that mask bit. A 1 written to the mask-set register (0x28) sets it. Writes to 0x20 have no effect.
- R8: `irq` is high exactly when some interrupt status bit is set and its mask bit is 0.
- R9: Status bit 8 and mask bit 8 are reserved and always read 0. Writes to the status register (0x04) change nothing. Unmapped offsets read 0.
- R10: The status register (0x04) shows `eng_rx_valid` at bit 5, `eng_tx_valid` at bit 6, `eng_rx_ovf` at bit 7 and `eng_busy` at bit 8. All other bits read 0.
- R11: The target address (0x08, 10 bits), timeout (0x1C, 8 bits) and pause (0x18, 4 bits) read back as written and appear on their outputs.
- R12: A write to data (0x0C) raises `fifo_push` in that cycle, with `fifo_push_data` set to bits 7:0. A read of 0x0C returns `fifo_rd_data` and raises `fifo_pop`. A write to 0x14 raises `xfer_len_wr` with `xfer_len` set to bits 7:0. A read of 0x14 returns `eng_xfer_left`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address (low two bits ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| evt_pulse | input | 10 | Event pulses from the transfer engine |
| eng_rx_valid | input | 1 | Receive data available |
| eng_tx_valid | input | 1 | Transmit data pending |
| eng_rx_ovf | input | 1 | Receive overflow flag |
| eng_busy | input | 1 | Bus active |
| eng_xfer_left | input | XS_W | Remaining transfer count |
| fifo_rd_data | input | BYTE_W | Head of receive FIFO |
| fifo_push | output | 1 | Transmit FIFO push strobe |
| fifo_push_data | output | BYTE_W | Byte to push |
| fifo_pop | output | 1 | Receive FIFO pop strobe |
| fifo_flush | output | 1 | One-cycle FIFO flush |
| xfer_len_wr | output | 1 | Transfer length load strobe |
| xfer_len | output | XS_W | Transfer length value |
| ctl_read | output | 1 | Direction, 1 = read |
| ctl_master | output | 1 | Master mode |
| ctl_addr7 | output | 1 | 7-bit addressing |
| ctl_ack_en | output | 1 | ACK enable |
| ctl_hold | output | 1 | Hold bus after transfer |
| ctl_slv_mon | output | 1 | Monitor mode |
| ctl_div_a | output | 2 | Divider stage A |
| ctl_div_b | output | 6 | Divider stage B |
| tgt_addr | output | TADDR_W | Target device address |
| tout_cycles | output | TOUT_W | Timeout value |
| mon_pause | output | PAUSE_W | Monitor pause value |
| irq | output | 1 | Combined interrupt |

## Verification
A hardware event and a software write-one-to-clear can reach the same sticky status bit in one clock. The bench provokes this by raising `evt_pulse` in the very cycle it writes ones to the interrupt status register, on bits that are already set. It then reads the register back and compares it with an arithmetic model in which the event is applied after the clear. Bits cleared without a competing event must read 0, and bits with a competing event must read 1.

// File: rtl/i2cm_csr_pkg.sv
package i2cm_csr_pkg;
  localparam int REG_W = 32;
  localparam int EVT_W = 10;

  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_STAT  = 'h04;
  localparam int OFF_TADR  = 'h08;
  localparam int OFF_DATA  = 'h0C;
  localparam int OFF_IST   = 'h10;
  localparam int OFF_XLEN  = 'h14;
  localparam int OFF_PAUSE = 'h18;
  localparam int OFF_TOUT  = 'h1C;
  localparam int OFF_MASK  = 'h20;
  localparam int OFF_UNMSK = 'h24;
  localparam int OFF_MSKON = 'h28;

  // event positions (bit 8 unused)
  localparam logic [EVT_W-1:0] EVT_IMPL = 10'h2FF;

  localparam int ST_RXV = 5;
  localparam int ST_TXV = 6;
  localparam int ST_RXO = 7;
  localparam int ST_BA  = 8;

  localparam int CT_FLAGS_W = 6;
  localparam int CT_CLRF    = 6;
  localparam int CT_DIVB_LO = 8;
  localparam int DIVB_W     = 6;
  localparam int CT_DIVA_LO = 14;
  localparam int DIVA_W     = 2;

  // sticky update: clear first, then events land on top
  function automatic logic [EVT_W-1:0] ist_next(input logic [EVT_W-1:0] cur,
                                                input logic [EVT_W-1:0] clr,
                                                input logic [EVT_W-1:0] evt);
    return ((cur & ~clr) | evt) & EVT_IMPL;
  endfunction

  function automatic logic [EVT_W-1:0] mask_next(input logic [EVT_W-1:0] cur,
                                                 input logic [EVT_W-1:0] unm,
                                                 input logic [EVT_W-1:0] mon);
    return ((cur & ~unm) | mon) & EVT_IMPL;
  endfunction
endpackage

// File: rtl/i2cm_ctrl_regs.sv
module i2cm_ctrl_regs
  import i2cm_csr_pkg::*;
#(
  parameter int TADDR_W = 10,
  parameter int TOUT_W  = 8,
  parameter int PAUSE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ctrl,
  input  logic                  wr_tadr,
  input  logic                  wr_tout,
  input  logic                  wr_pause,
  input  logic [REG_W-1:0]      wdata,
  output logic [CT_FLAGS_W-1:0] flags,
  output logic [DIVA_W-1:0]     div_a,
  output logic [DIVB_W-1:0]     div_b,
  output logic                  flush,
  output logic [TADDR_W-1:0]    tgt_addr,
  output logic [TOUT_W-1:0]     tout,
  output logic [PAUSE_W-1:0]    pause
);
  logic flush_req;
  assign flush_req = wr_ctrl & wdata[CT_CLRF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      div_a    <= '0;
      div_b    <= '0;
      flush    <= 1'b0;
      tgt_addr <= '0;
      tout     <= '0;
      pause    <= '0;
    end else begin
      flush <= flush_req;
      if (wr_ctrl) begin
        flags <= wdata[CT_FLAGS_W-1:0];
        div_b <= wdata[CT_DIVB_LO +: DIVB_W];
        div_a <= wdata[CT_DIVA_LO +: DIVA_W];
      end
      if (wr_tadr)  tgt_addr <= wdata[TADDR_W-1:0];
      if (wr_tout)  tout     <= wdata[TOUT_W-1:0];
      if (wr_pause) pause    <= wdata[PAUSE_W-1:0];
    end
  end
endmodule

// File: rtl/i2cm_irq_unit.sv
module i2cm_irq_unit
  import i2cm_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] clr_vec,
  input  logic [EVT_W-1:0] unm_vec,
  input  logic [EVT_W-1:0] mon_vec,
  input  logic [EVT_W-1:0] evt,
  output logic [EVT_W-1:0] ist_q,
  output logic [EVT_W-1:0] imask_q,
  output logic             irq
);
  logic [EVT_W-1:0] live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist_q   <= '0;
      imask_q <= EVT_IMPL;
    end else begin
      ist_q   <= ist_next(ist_q, clr_vec, evt);
      imask_q <= mask_next(imask_q, unm_vec, mon_vec);
    end
  end

  assign live = ist_q & ~imask_q;
  assign irq  = |live;
endmodule

// File: rtl/i2cm_csr.sv
module i2cm_csr
  import i2cm_csr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int TADDR_W = 10,
  parameter int XS_W    = 8,
  parameter int BYTE_W  = 8,
  parameter int TOUT_W  = 8,
  parameter int PAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_en,
  input  logic               bus_rd_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [9:0]         evt_pulse,
  input  logic               eng_rx_valid,
  input  logic               eng_tx_valid,
  input  logic               eng_rx_ovf,
  input  logic               eng_busy,
  input  logic [XS_W-1:0]    eng_xfer_left,
  input  logic [BYTE_W-1:0]  fifo_rd_data,
  output logic               fifo_push,
  output logic [BYTE_W-1:0]  fifo_push_data,
  output logic               fifo_pop,
  output logic               fifo_flush,
  output logic               xfer_len_wr,
  output logic [XS_W-1:0]    xfer_len,
  output logic               ctl_read,
  output logic               ctl_master,
  output logic               ctl_addr7,
  output logic               ctl_ack_en,
  output logic               ctl_hold,
  output logic               ctl_slv_mon,
  output logic [1:0]         ctl_div_a,
  output logic [5:0]         ctl_div_b,
  output logic [TADDR_W-1:0] tgt_addr,
  output logic [TOUT_W-1:0]  tout_cycles,
  output logic [PAUSE_W-1:0] mon_pause,
  output logic               irq
);
  localparam int NREG = 11;

  logic [ADDR_W-1:0] word_a;
  logic [NREG-1:0]   hit;
  logic              unused_bits;

  assign word_a = {bus_addr[ADDR_W-1:2], 2'b00};

  localparam int OFFS [NREG] = '{OFF_CTRL, OFF_STAT, OFF_TADR, OFF_DATA, OFF_IST,
                                 OFF_XLEN, OFF_PAUSE, OFF_TOUT, OFF_MASK,
                                 OFF_UNMSK, OFF_MSKON};
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign hit[g] = (word_a == ADDR_W'(OFFS[g]));
  end

  logic wr_ctrl, wr_tadr, wr_data, wr_ist, wr_xlen, wr_pause, wr_tout, wr_unm, wr_mon;
  assign wr_ctrl  = bus_wr_en & hit[0];
  assign wr_tadr  = bus_wr_en & hit[2];
  assign wr_data  = bus_wr_en & hit[3];
  assign wr_ist   = bus_wr_en & hit[4];
  assign wr_xlen  = bus_wr_en & hit[5];
  assign wr_pause = bus_wr_en & hit[6];
  assign wr_tout  = bus_wr_en & hit[7];
  assign wr_unm   = bus_wr_en & hit[9];
  assign wr_mon   = bus_wr_en & hit[10];

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:16]};

  logic [CT_FLAGS_W-1:0] flags;
  logic [EVT_W-1:0]      ist_q, imask_q;
  logic [EVT_W-1:0]      clr_vec, unm_vec, mon_vec;

  assign clr_vec = wr_ist ? bus_wdata[EVT_W-1:0] : '0;
  assign unm_vec = wr_unm ? bus_wdata[EVT_W-1:0] : '0;
  assign mon_vec = wr_mon ? bus_wdata[EVT_W-1:0] : '0;

  i2cm_ctrl_regs #(.TADDR_W(TADDR_W), .TOUT_W(TOUT_W), .PAUSE_W(PAUSE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_tadr  (wr_tadr),
    .wr_tout  (wr_tout),
    .wr_pause (wr_pause),
    .wdata    (bus_wdata),
    .flags    (flags),
    .div_a    (ctl_div_a),
    .div_b    (ctl_div_b),
    .flush    (fifo_flush),
    .tgt_addr (tgt_addr),
    .tout     (tout_cycles),
    .pause    (mon_pause)
  );

  i2cm_irq_unit u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_vec (clr_vec),
    .unm_vec (unm_vec),
    .mon_vec (mon_vec),
    .evt     (evt_pulse),
    .ist_q   (ist_q),
    .imask_q (imask_q),
    .irq     (irq)
  );

  assign {ctl_slv_mon, ctl_hold, ctl_ack_en, ctl_addr7, ctl_master, ctl_read} = flags;

  assign fifo_push      = wr_data;
  assign fifo_push_data = bus_wdata[BYTE_W-1:0];
  assign fifo_pop       = bus_rd_en & hit[3];
  assign xfer_len_wr    = wr_xlen;
  assign xfer_len       = bus_wdata[XS_W-1:0];

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      hit[0]: begin
        bus_rdata[CT_FLAGS_W-1:0]          = flags;
        bus_rdata[CT_CLRF]                 = fifo_flush;
        bus_rdata[CT_DIVB_LO +: DIVB_W]    = ctl_div_b;
        bus_rdata[CT_DIVA_LO +: DIVA_W]    = ctl_div_a;
      end
      hit[1]: begin
        bus_rdata[ST_RXV] = eng_rx_valid;
        bus_rdata[ST_TXV] = eng_tx_valid;
        bus_rdata[ST_RXO] = eng_rx_ovf;
        bus_rdata[ST_BA]  = eng_busy;
      end
      hit[2]:  bus_rdata[TADDR_W-1:0] = tgt_addr;
      hit[3]:  bus_rdata[BYTE_W-1:0]  = fifo_rd_data;
      hit[4]:  bus_rdata[EVT_W-1:0]   = ist_q;
      hit[5]:  bus_rdata[XS_W-1:0]    = eng_xfer_left;
      hit[6]:  bus_rdata[PAUSE_W-1:0] = mon_pause;
      hit[7]:  bus_rdata[TOUT_W-1:0]  = tout_cycles;
      hit[8]:  bus_rdata[EVT_W-1:0]   = imask_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cm_csr_chk.sv
module i2cm_csr_chk
  import i2cm_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [EVT_W-1:0]  evt_pulse,
  input logic [EVT_W-1:0]  ist_q,
  input logic [EVT_W-1:0]  imask_q,
  input logic              irq,
  input logic              fifo_flush
);
  logic [ADDR_W-1:0] wa;
  logic              w_ctrl, w_ist, w_unm, w_mon;
  logic [EVT_W-1:0]  c_clr, c_unm, c_mon, c_evt;

  assign wa     = {bus_addr[ADDR_W-1:2], 2'b00};
  assign w_ctrl = bus_wr_en && wa == ADDR_W'(OFF_CTRL);
  assign w_ist  = bus_wr_en && wa == ADDR_W'(OFF_IST);
  assign w_unm  = bus_wr_en && wa == ADDR_W'(OFF_UNMSK);
  assign w_mon  = bus_wr_en && wa == ADDR_W'(OFF_MSKON);
  assign c_clr  = w_ist ? bus_wdata[EVT_W-1:0] : '0;
  assign c_unm  = w_unm ? bus_wdata[EVT_W-1:0] : '0;
  assign c_mon  = w_mon ? (bus_wdata[EVT_W-1:0] & EVT_IMPL) : '0;
  assign c_evt  = evt_pulse & EVT_IMPL;

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flush && !(w_ctrl && bus_wdata[CT_CLRF])) |=> !fifo_flush); // R3
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> $past(w_ctrl && bus_wdata[CT_CLRF])); // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ist_q) & ~ist_q & ~$past(c_clr)) == '0)); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((ist_q & $past(c_clr & ~c_evt)) == '0)); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ist_q & $past(c_evt)) == $past(c_evt))); // R6
  AST_UNMASK_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ((imask_q & $past(c_unm)) == '0)); // R7
  AST_MASKON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ((imask_q & $past(c_mon)) == $past(c_mon))); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_q == '0 || imask_q == EVT_IMPL) |-> !irq); // R8
endmodule

bind i2cm_csr i2cm_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr_en  (bus_wr_en),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .evt_pulse  (evt_pulse),
  .ist_q      (ist_q),
  .imask_q    (imask_q),
  .irq        (irq),
  .fifo_flush (fifo_flush)
);

// File: tb/sim_i2cm_csr.sv
`timescale 1ns/1ps
module sim_i2cm_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  evt = '0;
  logic        rxv = 0, txv = 0, rxo = 0, busy = 0;
  logic [7:0]  xleft = '0, frd = '0;
  logic        push, pop, flush, xwr, irq;
  logic [7:0]  push_d, xlen;
  logic        c_rd, c_ms, c_a7, c_ack, c_hold, c_mon;
  logic [1:0]  c_da;
  logic [5:0]  c_db;
  logic [9:0]  taddr;
  logic [7:0]  tout;
  logic [3:0]  pause;

  int n_chk = 0, n_err = 0;
  logic [9:0] m_ist = '0, m_mask = 10'h2FF;
  localparam logic [9:0] IMPL = 10'h2FF;

  always #2.5 clk = ~clk;

  i2cm_csr u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr), .bus_rd_en(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .evt_pulse(evt), .eng_rx_valid(rxv),
    .eng_tx_valid(txv), .eng_rx_ovf(rxo), .eng_busy(busy), .eng_xfer_left(xleft),
    .fifo_rd_data(frd), .fifo_push(push), .fifo_push_data(push_d), .fifo_pop(pop),
    .fifo_flush(flush), .xfer_len_wr(xwr), .xfer_len(xlen), .ctl_read(c_rd),
    .ctl_master(c_ms), .ctl_addr7(c_a7), .ctl_ack_en(c_ack), .ctl_hold(c_hold),
    .ctl_slv_mon(c_mon), .ctl_div_a(c_da), .ctl_div_b(c_db), .tgt_addr(taddr),
    .tout_cycles(tout), .mon_pause(pause), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); rd = 1; addr = a;
    #1 chk(tag, rdata, exp);
    @(negedge clk); rd = 0;
  endtask

  task automatic pulse(input logic [9:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
    m_ist = (m_ist | v) & IMPL;
  endtask

  function automatic logic exp_irq();
    return |(m_ist & ~m_mask & IMPL);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk("R1 ctrl", 8'h00, 0);
    rd_chk("R1 taddr", 8'h08, 0);
    rd_chk("R1 tout", 8'h1C, 0);
    rd_chk("R1 pause", 8'h18, 0);
    rd_chk("R1 mask", 8'h20, 32'h2FF);
    rd_chk("R1 ist", 8'h10, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 flush", {31'b0, flush}, 0);

    // R10 status sweep
    for (int s = 0; s < 16; s++) begin
      {busy, rxo, txv, rxv} = s[3:0];
      rd_chk("R10 status", 8'h04, 32'(s) << 5);
    end
    {busy, rxo, txv, rxv} = '0;

    // R2 control bit sweep (bit 6 handled in R3)
    for (int b = 0; b < 32; b++) begin
      if (b != 6) begin
        wr32(8'h00, 32'h1 << b);
        rd_chk("R2 ctrl readback", 8'h00, (32'h1 << b) & 32'h0000_FF3F);
        chk("R2 ctrl outputs", {16'b0, c_da, c_db, 2'b0, c_mon, c_hold, c_ack, c_a7, c_ms, c_rd},
            (32'h1 << b) & 32'h0000_FF3F);
      end
    end

    // R3 clear-FIFO self clears
    wr32(8'h00, 32'h43);
    #1 chk("R3 flush high", {31'b0, flush}, 1);
    chk("R3 bit6 set", rdata, 32'h43);
    @(negedge clk);
    #1 chk("R3 flush low", {31'b0, flush}, 0);
    chk("R3 bit6 clear", rdata, 32'h03);

    // R11 simple registers
    wr32(8'h08, 32'hFFFF_FEA5); rd_chk("R11 taddr", 8'h08, 32'h2A5);
    chk("R11 taddr out", {22'b0, taddr}, 32'h2A5);
    wr32(8'h1C, 32'hFFFF_FF5A); rd_chk("R11 tout", 8'h1C, 32'h5A);
    chk("R11 tout out", {24'b0, tout}, 32'h5A);
    wr32(8'h18, 32'hFFFF_FFF9); rd_chk("R11 pause", 8'h18, 32'h9);
    chk("R11 pause out", {28'b0, pause}, 32'h9);

    // R12 data and length strobes
    @(negedge clk); wr = 1; addr = 8'h0C; wdata = 32'h1234_56C3;
    #1 chk("R12 push", {23'b0, push, push_d}, 32'h1C3);
    @(negedge clk); wr = 0;
    #1 chk("R12 push idle", {31'b0, push}, 0);
    frd = 8'h9E;
    @(negedge clk); rd = 1; addr = 8'h0C;
    #1 chk("R12 pop", {23'b0, pop, rdata[7:0]}, 32'h19E);
    @(negedge clk); rd = 0;
    @(negedge clk); wr = 1; addr = 8'h14; wdata = 32'hAB37;
    #1 chk("R12 len wr", {23'b0, xwr, xlen}, 32'h137);
    @(negedge clk); wr = 0;
    xleft = 8'h11;
    rd_chk("R12 len left", 8'h14, 32'h11);

    // R4 R5 R7 R8 per-event sweep
    for (int i = 0; i < 10; i++) begin
      logic [9:0] b;
      b = 10'h1 << i;
      pulse(b);
      rd_chk("R4 sticky set", 8'h10, 32'(m_ist));
      chk("R8 masked irq", {31'b0, irq}, 32'(exp_irq()));
      wr32(8'h24, 32'(b)); m_mask = m_mask & ~b & IMPL;
      rd_chk("R7 unmask", 8'h20, 32'(m_mask));
      chk("R8 unmasked irq", {31'b0, irq}, 32'(exp_irq()));
      wr32(8'h10, 32'(b)); m_ist = m_ist & ~b;
      rd_chk("R5 w1c", 8'h10, 32'(m_ist));
      chk("R8 irq after clear", {31'b0, irq}, 32'(exp_irq()));
      wr32(8'h28, 32'(b)); m_mask = (m_mask | b) & IMPL;
      rd_chk("R7 mask on", 8'h20, 32'(m_mask));
    end

    // R5 bulk clear of low bits
    pulse(10'h3FF);
    rd_chk("R9 ist rsvd bit", 8'h10, 32'h2FF);
    wr32(8'h10, 32'hFF); m_ist = m_ist & ~10'hFF;
    rd_chk("R5 0xFF clear", 8'h10, 32'h200);
    wr32(8'h10, 32'h0);
    rd_chk("R5 zeros keep", 8'h10, 32'h200);
    wr32(8'h10, 32'h200); m_ist = '0;
    rd_chk("R5 arb clear", 8'h10, 0);

    // R6 event vs clear in the same cycle
    pulse(10'h005);
    @(negedge clk); wr = 1; addr = 8'h10; wdata = 32'h3FF; evt = 10'h001;
    @(negedge clk); wr = 0; evt = '0;
    m_ist = ((m_ist & ~10'h3FF) | 10'h001) & IMPL;
    rd_chk("R6 event wins", 8'h10, 32'(m_ist));
    pulse(10'h0C0);
    @(negedge clk); wr = 1; addr = 8'h10; wdata = 32'h040; evt = 10'h040;
    @(negedge clk); wr = 0; evt = '0;
    rd_chk("R6 event wins again", 8'h10, 32'(m_ist));

    // R7 direct mask write ignored, bulk unmask and mask
    wr32(8'h20, 32'h0);
    rd_chk("R7 mask wr ignored", 8'h20, 32'h2FF);
    wr32(8'h24, 32'hFFFF_FFFF); m_mask = '0;
    rd_chk("R9 mask rsvd", 8'h20, 0);
    chk("R8 irq all open", {31'b0, irq}, 32'(exp_irq()));
    wr32(8'h28, 32'h0F0); m_mask = 10'h0F0;
    rd_chk("R7 partial mask", 8'h20, 32'h0F0);
    wr32(8'h10, 32'h3FF); m_ist = '0;
    pulse(10'h010);
    chk("R8 masked event", {31'b0, irq}, 32'(exp_irq()));
    pulse(10'h002);
    chk("R8 open event", {31'b0, irq}, 32'(exp_irq()));

    // R9 ignored writes and unmapped offsets
    wr32(8'h04, 32'hFFFF_FFFF);
    rd_chk("R9 status wr ignored", 8'h04, 0);
    rd_chk("R9 unmapped", 8'h2C, 0);
    rd_chk("R9 unmask reads 0", 8'h24, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule